// File: doc/BRIEF.md
# Quad-data-rate four-word burst SRAM

This block is a synthesizable on-chip model of a burst static memory with one read port and one write port that work independently. Every accepted request moves a burst of four data words. The data buses are two words wide, and each cycle carries two beats: the low word stands for the rising-clock beat and the high word for the inverted-clock beat. So a burst takes two cycles on either port. The storage is a small array with one row per burst address. Each row holds the four words of a burst, so word k of burst A sits at word address {A, k}, and the two low bits never appear on the address bus.

Read and write requests share one address bus by taking turns. After reset, cycles alternate between a read slot and a write slot, starting with a read slot. In a read slot the block samples the active-low read select and takes the address as a read address. In a write slot it samples the active-low write select and takes the address as a write address. In that same write-slot cycle it captures the first two write words. The last two words follow in the next cycle, which is a read slot. Active-low byte selects mask each beat separately.

A read in the same slot as a write is ordered before that write. A read whose cycle carries the tail of an earlier write to the same row gets the merged new data forwarded to it. Read data leaves through a registered output with a valid flag.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is low, rvalid is 0 and rdata is 0. The first rising clock edge after reset is released samples a read slot.
- R2: Slots alternate between read and write on every clock edge. rd_sel_n is honoured only in a read slot. wr_sel_n is honoured only in a write slot, and in that slot addr is the write address. A select driven low in the wrong slot has no effect on the array or on rvalid.
- R3: Burst row A holds word k (k = 0..3) at bits [k*DATA_W +: DATA_W] of the row. A read returns all four words in order of k.
- R4: In the write-slot cycle, wdata[DATA_W-1:0] is word 0 and wdata[2*DATA_W-1:DATA_W] is word 1. In the following cycle the same two fields carry word 2 and word 3.
- R5: wbe_n[j] governs byte j of wdata, which is bits [8j +: 8], in the cycle it is driven. A low bit writes that byte. A high bit leaves the stored byte unchanged.
- R6: A read sampled in cycle c raises rvalid in cycles c+1 and c+2. rdata holds {word1, word0} in cycle c+1 and {word3, word2} in cycle c+2. rdata is 0 whenever rvalid is low, and rvalid is never high without a read one or two cycles earlier.
- R7: A read and a write in the same slot are both serviced. The read returns the row as it stood before that write. It includes every earlier write, including one whose last two words arrive in the read's own cycle, merged under that write's byte masks.
- R8: A slot in which both selects are high changes no row and raises no rvalid, whatever addr, wdata and wbe_n carry.
- R9: Reads in consecutive read slots keep rvalid high without a gap, with each burst's four words in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle carries two data beats |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel_n | input | 1 | Active-low read request, sampled in read slots |
| wr_sel_n | input | 1 | Active-low write request, sampled in write slots |
| addr | input | ADDR_W | Burst address: read address in read slots, write address in write slots |
| wdata | input | 2*DATA_W | Two write beats; low word is the first beat |
| wbe_n | input | 2*BYTES | Active-low byte write selects for the two beats |
| rdata | output | 2*DATA_W | Two read beats; low word is the first beat |
| rvalid | output | 1 | High while rdata carries burst words |

## Verification
A read sampled at a clock edge is due one cycle later as words 0 and 1, and two cycles later as words 2 and 3. A write changes the array only when its second cycle ends, so a read in that second cycle already sees the write. The bench drives inputs and checks outputs on the falling edge. It holds a two-deep queue of expected output beats, which shifts once per cycle, so each read's words are compared exactly one and two cycles after the read was issued. Every other cycle is checked for rvalid low and rdata zero. The bench applies each write to its own reference memory in the read-slot cycle that carries the write's tail. It does this before it computes any read in that cycle, which gives both the forwarding rule and the rule that a same-slot write comes after the read.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int BYTE_W    = 8;
  localparam int BURST_LEN = 4;
  localparam int BEATS_CYC = 2;

  typedef enum logic {
    SLOT_RD = 1'b0,
    SLOT_WR = 1'b1
  } slot_e;
endpackage

// File: rtl/qdr_slot_ctrl.sv
module qdr_slot_ctrl
  import qdr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rd_sel_n,
  input  logic  wr_sel_n,
  output slot_e slot,
  output logic  rd_fire,
  output logic  wr_fire
);
  slot_e slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= SLOT_RD;
    else        slot_q <= (slot_q == SLOT_RD) ? SLOT_WR : SLOT_RD;
  end

  assign slot    = slot_q;
  assign rd_fire = (slot_q == SLOT_RD) && !rd_sel_n;
  assign wr_fire = (slot_q == SLOT_WR) && !wr_sel_n;
endmodule

// File: rtl/qdr_wr_stage.sv
module qdr_wr_stage
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_fire,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [BEATS_CYC*DATA_W-1:0]   wdata,
  input  logic [BEATS_CYC*DATA_W/BYTE_W-1:0] wbe_n,
  output logic                          cm_en,
  output logic [ADDR_W-1:0]             cm_addr,
  output logic [BURST_LEN*DATA_W-1:0]   cm_data,
  output logic [BURST_LEN*DATA_W/BYTE_W-1:0] cm_mask_n
);
  localparam int HALF_W = BEATS_CYC * DATA_W;
  localparam int HALF_M = HALF_W / BYTE_W;

  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HALF_W-1:0] head_q;
  logic [HALF_M-1:0] head_m_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      addr_q   <= '0;
      head_q   <= '0;
      head_m_q <= '1;
    end else begin
      pend_q <= wr_fire;
      if (wr_fire) begin
        addr_q   <= addr;
        head_q   <= wdata;
        head_m_q <= wbe_n;
      end
    end
  end

  // The tail beats arrive in the cycle after the request and complete the row.
  assign cm_en     = pend_q;
  assign cm_addr   = addr_q;
  assign cm_data   = {wdata, head_q};
  assign cm_mask_n = {wbe_n, head_m_q};

  p_commit_follows_write_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (cm_en && cm_addr == $past(addr) && cm_data[HALF_W-1:0] == $past(wdata)));
endmodule

// File: rtl/qdr_row_array.sv
module qdr_row_array
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          cm_en,
  input  logic [ADDR_W-1:0]             cm_addr,
  input  logic [BURST_LEN*DATA_W-1:0]   cm_data,
  input  logic [BURST_LEN*DATA_W/BYTE_W-1:0] cm_mask_n,
  input  logic                          rd_fire,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          fwd_hit,
  output logic [BURST_LEN*DATA_W-1:0]   rd_row
);
  localparam int ROWS  = 1 << ADDR_W;
  localparam int ROW_W = BURST_LEN * DATA_W;
  localparam int ROW_M = ROW_W / BYTE_W;

  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] rd_src;
  logic [ROW_W-1:0] rd_merged;
  logic [ROW_W-1:0] wr_merged;

  function automatic logic [ROW_W-1:0] merge_row(
    input logic [ROW_W-1:0] old_r,
    input logic [ROW_W-1:0] new_r,
    input logic [ROW_M-1:0] keep_n
  );
    logic [ROW_W-1:0] res;
    for (int b = 0; b < ROW_M; b++)
      res[b*BYTE_W +: BYTE_W] = keep_n[b] ? old_r[b*BYTE_W +: BYTE_W]
                                          : new_r[b*BYTE_W +: BYTE_W];
    return res;
  endfunction

  assign fwd_hit   = cm_en && (cm_addr == rd_addr);
  assign rd_src    = mem[rd_addr];
  assign rd_merged = merge_row(rd_src, cm_data, cm_mask_n);
  assign wr_merged = merge_row(mem[cm_addr], cm_data, cm_mask_n);

  always_ff @(posedge clk) begin
    if (cm_en) mem[cm_addr] <= wr_merged;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_row <= fwd_hit ? rd_merged : rd_src;
  end
endmodule

// File: rtl/qdr_rd_out.sv
module qdr_rd_out
  import qdr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_fire,
  input  logic [BURST_LEN*DATA_W-1:0]   rd_row,
  output logic [BEATS_CYC*DATA_W-1:0]   rdata,
  output logic                          rvalid
);
  localparam int HALF_W = BEATS_CYC * DATA_W;

  logic beat_lo_q;
  logic beat_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_lo_q <= 1'b0;
      beat_hi_q <= 1'b0;
    end else begin
      beat_lo_q <= rd_fire;
      beat_hi_q <= beat_lo_q;
    end
  end

  always_comb begin
    if (beat_lo_q)      rdata = rd_row[HALF_W-1:0];
    else if (beat_hi_q) rdata = rd_row[2*HALF_W-1:HALF_W];
    else                rdata = '0;
  end

  assign rvalid = beat_lo_q | beat_hi_q;
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int BYTES  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_sel_n,
  input  logic                              wr_sel_n,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [BEATS_CYC*BYTES*BYTE_W-1:0] wdata,
  input  logic [BEATS_CYC*BYTES-1:0]        wbe_n,
  output logic [BEATS_CYC*BYTES*BYTE_W-1:0] rdata,
  output logic                              rvalid
);
  localparam int DATA_W = BYTES * BYTE_W;
  localparam int ROW_W  = BURST_LEN * DATA_W;
  localparam int ROW_M  = BURST_LEN * BYTES;

  slot_e              slot;
  logic               rd_fire;
  logic               wr_fire;
  logic               cm_en;
  logic [ADDR_W-1:0]  cm_addr;
  logic [ROW_W-1:0]   cm_data;
  logic [ROW_M-1:0]   cm_mask_n;
  logic               fwd_hit;
  logic [ROW_W-1:0]   rd_row;

  qdr_slot_ctrl u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .slot     (slot),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire)
  );

  qdr_wr_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .addr      (addr),
    .wdata     (wdata),
    .wbe_n     (wbe_n),
    .cm_en     (cm_en),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data),
    .cm_mask_n (cm_mask_n)
  );

  qdr_row_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk       (clk),
    .cm_en     (cm_en),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data),
    .cm_mask_n (cm_mask_n),
    .rd_fire   (rd_fire),
    .rd_addr   (addr),
    .fwd_hit   (fwd_hit),
    .rd_row    (rd_row)
  );

  qdr_rd_out #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_fire (rd_fire),
    .rd_row  (rd_row),
    .rdata   (rdata),
    .rvalid  (rvalid)
  );

  p_valid_after_read_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid);

  p_valid_window_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(rd_fire) || $past(rd_fire, 2)));

  p_commit_in_read_slot_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    cm_en |-> (slot == SLOT_RD));

  p_nop_no_commit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_WR && wr_sel_n) |=> !cm_en);

  p_forward_only_on_commit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (slot == SLOT_RD));
endmodule

// File: tb/test_qdr_burst_sram.sv
`timescale 1ns/1ps
module test_qdr_burst_sram;
  localparam int AW   = 5;
  localparam int BY   = 2;
  localparam int DW   = BY * 8;
  localparam int HW   = 2 * DW;
  localparam int RW   = 4 * DW;
  localparam int RM   = 4 * BY;
  localparam int ROWS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_sel_n = 1'b1;
  logic          wr_sel_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [HW-1:0] wdata = '0;
  logic [2*BY-1:0] wbe_n = '1;
  logic [HW-1:0] rdata;
  logic          rvalid;

  qdr_burst_sram #(.ADDR_W(AW), .BYTES(BY)) i_qdr_burst_sram (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int k      = 0;

  logic [RW-1:0] ref_mem [ROWS];
  logic          wp = 1'b0;
  logic [AW-1:0] wp_a;
  logic [HW-1:0] wp_d;
  logic [2*BY-1:0] wp_m;
  logic          e1_v = 1'b0, e2_v = 1'b0;
  logic [HW-1:0] e1_d, e2_d;
  string         e1_tag, e2_tag;
  logic [HW-1:0] tail_d = '0;
  logic [2*BY-1:0] tail_m = '1;

  function automatic logic [RW-1:0] bmerge(input logic [RW-1:0] old_r,
                                           input logic [RW-1:0] new_r,
                                           input logic [RM-1:0] m_n);
    logic [RW-1:0] keep;
    for (int b = 0; b < RM; b++) keep[b*8 +: 8] = {8{m_n[b]}};
    return (old_r & keep) | (new_r & ~keep);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [HW:0] act, input logic [HW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, k, act, exp);
    end
  endtask

  // Called at a falling edge: check this cycle's outputs, then drive cycle k.
  task automatic cyc(input logic rn, input logic wn, input logic [AW-1:0] a,
                     input logic [HW-1:0] d, input logic [2*BY-1:0] m,
                     input string tag);
    logic [RW-1:0] r;
    if (e1_v) chk(rvalid === 1'b1 && rdata === e1_d, e1_tag, {rvalid, rdata}, {1'b1, e1_d});
    else      chk(rvalid === 1'b0 && rdata === '0, "R6", {rvalid, rdata}, '0);
    e1_v = e2_v; e1_d = e2_d; e1_tag = e2_tag; e2_v = 1'b0;
    rd_sel_n = rn; wr_sel_n = wn; addr = a; wdata = d; wbe_n = m;
    if (k % 2 == 0) begin
      if (wp) begin
        ref_mem[wp_a] = bmerge(ref_mem[wp_a], {d, wp_d}, {m, wp_m});
        wp = 1'b0;
      end
      if (!rn) begin
        r = ref_mem[a];
        e1_v = 1'b1; e1_d = r[HW-1:0];  e1_tag = tag;
        e2_v = 1'b1; e2_d = r[RW-1:HW]; e2_tag = tag;
      end
    end else if (!wn) begin
      wp = 1'b1; wp_a = a; wp_d = d; wp_m = m;
    end
    k++;
    @(negedge clk);
  endtask

  // One read slot followed by one write slot; bad drives the off-slot select low.
  task automatic slot(input logic rn, input logic [AW-1:0] ra,
                      input logic wn, input logic [AW-1:0] wa,
                      input logic [RW-1:0] wrow, input logic [RM-1:0] wm,
                      input bit bad, input string tag);
    cyc(rn, bad ? 1'b0 : 1'b1, ra, tail_d, tail_m, tag);
    cyc(bad ? 1'b0 : 1'b1, wn, wa, wrow[HW-1:0], wm[2*BY-1:0], tag);
    tail_d = wrow[RW-1:HW];
    tail_m = wn ? '1 : wm[RM-1:2*BY];
  endtask

  function automatic logic [RW-1:0] pat(input int row);
    logic [RW-1:0] v;
    for (int w = 0; w < 4; w++) v[w*DW +: DW] = DW'(16'hA000 + row * 16 + w);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    chk(rvalid === 1'b0 && rdata === '0, "R1", {rvalid, rdata}, '0);
    rst_n = 1'b1;

    // R1: first cycle is a read slot; off-slot selects must be ignored.
    slot(1'b1, '0, 1'b0, AW'(0), pat(0), '0, 1'b1, "R1");
    for (int i = 1; i < ROWS; i++) slot(1'b1, '0, 1'b0, AW'(i), pat(i), '0, 1'b0, "R3");
    slot(1'b0, AW'(0), 1'b1, '0, '0, '1, 1'b0, "R1");
    // R3: every row reads back with its words in order
    for (int i = 1; i < ROWS; i++) slot(1'b0, AW'(i), 1'b1, '0, '0, '1, 1'b0, "R3");

    // R4: distinct beats, full write, read two slots later
    slot(1'b1, '0, 1'b0, AW'(12), 64'h4444_3333_2222_1111, '0, 1'b0, "R4");
    slot(1'b1, '0, 1'b1, '0, '0, '1, 1'b0, "R4");
    slot(1'b0, AW'(12), 1'b1, '0, '0, '1, 1'b0, "R4");

    // R5: per-byte masks across both cycles
    slot(1'b1, '0, 1'b0, AW'(7), 64'hDEAD_BEEF_CAFE_F00D, 8'b1010_0101, 1'b0, "R5");
    slot(1'b1, '0, 1'b1, '0, '0, '1, 1'b0, "R5");
    slot(1'b0, AW'(7), 1'b1, '0, '0, '1, 1'b0, "R5");

    // R7: read in the tail cycle of a masked write is forwarded
    slot(1'b1, '0, 1'b0, AW'(9), 64'h0123_4567_89AB_CDEF, 8'b0110_1001, 1'b0, "R7");
    slot(1'b0, AW'(9), 1'b1, '0, '0, '1, 1'b0, "R7");
    // R7: same-slot read and write of one row: read sees old data
    slot(1'b0, AW'(10), 1'b0, AW'(10), 64'h5555_6666_7777_8888, '0, 1'b0, "R7");
    slot(1'b0, AW'(10), 1'b1, '0, '0, '1, 1'b0, "R7");

    // R8: NOP slots with busy buses change nothing
    for (int i = 0; i < 3; i++) slot(1'b1, AW'(13), 1'b1, AW'(13), 64'hFFFF_0000_FFFF_0000, '0, 1'b0, "R8");
    slot(1'b0, AW'(13), 1'b1, '0, '0, '1, 1'b0, "R8");

    // R2: selects in the wrong slot are ignored
    slot(1'b1, AW'(11), 1'b1, AW'(11), 64'hBAD0_BAD1_BAD2_BAD3, '0, 1'b1, "R2");
    slot(1'b1, AW'(11), 1'b1, AW'(11), 64'hBAD4_BAD5_BAD6_BAD7, '0, 1'b1, "R2");
    slot(1'b0, AW'(11), 1'b1, '0, '0, '1, 1'b0, "R2");

    // R9: back-to-back reads
    for (int i = 1; i <= 4; i++) slot(1'b0, AW'(i), 1'b1, '0, '0, '1, 1'b0, "R9");

    // R7: random concurrent traffic against the reference memory
    for (int i = 0; i < 300; i++) begin
      logic [RM-1:0] m;
      m = ($urandom_range(0, 3) == 0) ? '0 : RM'($urandom);
      slot(1'($urandom), AW'($urandom), 1'($urandom), AW'($urandom),
           {$urandom, $urandom}, m, 1'($urandom_range(0, 4) == 0), "R7");
    end

    for (int i = 0; i < 3; i++) slot(1'b1, '0, 1'b1, '0, '0, '1, 1'b0, "R6");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule